// File: doc/BRIEF.md
# Branch Shadow Resolution Unit

This block follows a single conditional branch that is in flight inside a scoreboard-driven out-of-order core. When the branch issues, the unit records which direction was predicted and the program counter of the path that was not predicted. From the next cycle it holds a write-inhibit line high. Operations under that shadow may compute, but none may write the register file or memory.

When the branch later resolves, the unit compares the direction it took with the recorded prediction. If they agree, it drops the shadow with a one-cycle success pulse. If they differ, it drops the shadow with a one-cycle cancel pulse and sends fetch the stored alternative address. A misprediction therefore needs no rollback: the speculative writes never took place. The direction predictor gets its taken/not-taken training only in the same cycle that the shadow falls, when the branch is no longer speculative.

The unit accepts a new issue from the cycle after the outcome pulse. Resolution flags that are contradictory or that arrive at the wrong time are discarded, and an error pulse reports them.

Top module: `branch_shadow_unit`

## Requirements
- R1: An issue is accepted when `issue_valid` is high on a clock edge at which `issue_ready` is high. `write_inhibit` is high from the next cycle and stays high until the cycle in which the outcome pulse appears. In that cycle it is low.
- R2: An accepted issue captures `issue_pred_then` (1 = THEN path predicted, 0 = ELSE path predicted) and `issue_alt_pc`. While `issue_ready` is low, `issue_valid` is ignored and the captured values do not change.
- R3: While the shadow is active, a cycle with exactly one of `res_then` and `res_else` high resolves the branch. A cycle with neither flag high leaves the shadow in place.
- R4: The cycle after resolution shows exactly one of `success` and `cancel`. `success` appears when the actual direction equals the captured prediction, and `cancel` appears otherwise.
- R5: Together with `cancel`, `redirect_valid` is high and `redirect_pc` equals the captured alternative address. At all other times `redirect_valid` is low and `redirect_pc` is zero.
- R6: `train_valid` pulses only in the outcome cycle, while `write_inhibit` is low. `train_then` then gives the actual direction (1 = THEN); at other times `train_then` is zero.
- R7: If both resolution flags are high on the same edge, or either flag is high while no shadow is active, the flags are ignored and `err` pulses high for one cycle after that edge.
- R8: `success`, `cancel`, `redirect_valid` and `train_valid` last exactly one cycle. `issue_ready` returns high in the cycle that follows them.
- R9: A synchronous active-low reset clears the shadow, the captured direction and the captured address. While reset is applied and after it, all pulse outputs are low and `issue_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | A branch is presented for issue |
| issue_pred_then | input | 1 | Predicted direction: 1 = THEN, 0 = ELSE |
| issue_alt_pc | input | PC_W | Address of the path that was not predicted |
| issue_ready | output | 1 | Unit is idle and will accept an issue |
| res_then | input | 1 | Branch resolved to the THEN path |
| res_else | input | 1 | Branch resolved to the ELSE path |
| write_inhibit | output | 1 | Shadow active: block writes by shadowed operations |
| success | output | 1 | One-cycle pulse: prediction was correct |
| cancel | output | 1 | One-cycle pulse: prediction was wrong, discard shadowed work |
| redirect_valid | output | 1 | One-cycle pulse: restart issue at `redirect_pc` |
| redirect_pc | output | PC_W | Stored alternative address during a redirect, otherwise zero |
| train_valid | output | 1 | One-cycle pulse: non-speculative training for the predictor |
| train_then | output | 1 | Actual direction for training (1 = THEN) |
| err | output | 1 | One-cycle pulse: resolution flags were ignored |

## Verification
Every result appears one register stage after the edge that samples its cause. `write_inhibit` rises in the cycle after the issue edge. The outcome, redirect, training and error pulses appear in the cycle after the resolving or offending edge. `issue_ready` returns one cycle after the pulses. The bench drives inputs 1 ns after a rising edge and samples outputs 1 ns after the next rising edge, so each check reads exactly the cycle in which its result is due. It checks again on the following cycle to confirm that each pulse has ended.

// File: rtl/bsu_pkg.sv
// Shared types for the branch shadow unit.
// Assumes a single tracked branch; the state encoding is local to the unit.
package bsu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHADOW = 2'd1,
        ST_RETIRE = 2'd2
    } bsu_state_e;
endpackage

// File: rtl/bsu_ctrl.sv
// Control FSM: idle -> shadow on issue, shadow -> retire on a clean resolution,
// retire -> idle after one cycle. Also flags malformed resolution inputs.
// Assumes the resolution flags are synchronous to clk.
module bsu_ctrl
    import bsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue_valid,
    input  logic       res_then,
    input  logic       res_else,
    output bsu_state_e state,
    output logic       capture_en,
    output logic       resolve_en,
    output logic       err
);
    bsu_state_e state_d;
    logic       any_flag;
    logic       bad_flags;

    // Decode accept, resolve and error conditions from current state and inputs.
    always_comb begin
        any_flag   = res_then | res_else;
        capture_en = (state == ST_IDLE) && issue_valid;
        resolve_en = (state == ST_SHADOW) && (res_then ^ res_else);
        bad_flags  = (res_then & res_else) || (any_flag && (state != ST_SHADOW));
    end

    // Next-state selection.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:   if (capture_en) state_d = ST_SHADOW;
            ST_SHADOW: if (resolve_en) state_d = ST_RETIRE;
            ST_RETIRE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State and error-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            err   <= 1'b0;
        end else begin
            state <= state_d;
            err   <= bad_flags;
        end
    end
endmodule

// File: rtl/bsu_store.sv
// Holds the predicted direction and the alternative PC of the tracked branch.
// Assumes capture_en is only raised while the unit is idle.
module bsu_store #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_en,
    input  logic            pred_then_in,
    input  logic [PC_W-1:0] alt_pc_in,
    output logic            pred_then,
    output logic [PC_W-1:0] alt_pc
);
    // Capture on accepted issue; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_then <= 1'b0;
            alt_pc    <= '0;
        end else if (capture_en) begin
            pred_then <= pred_then_in;
            alt_pc    <= alt_pc_in;
        end
    end
endmodule

// File: rtl/bsu_outcome.sv
// Compares the actual direction with the stored prediction and registers the
// one-cycle outcome, redirect and training pulses.
// Assumes resolve_en is raised for exactly one cycle per tracked branch.
module bsu_outcome #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            resolve_en,
    input  logic            actual_then,
    input  logic            pred_then,
    input  logic [PC_W-1:0] alt_pc,
    output logic            success,
    output logic            cancel,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic            train_valid,
    output logic            train_then
);
    logic mispredict;

    // Direction comparison.
    always_comb mispredict = (actual_then != pred_then);

    // Outcome pulse registers; all return to zero when no resolution occurs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            success        <= 1'b0;
            cancel         <= 1'b0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            train_valid    <= 1'b0;
            train_then     <= 1'b0;
        end else begin
            success        <= resolve_en && !mispredict;
            cancel         <= resolve_en && mispredict;
            redirect_valid <= resolve_en && mispredict;
            redirect_pc    <= (resolve_en && mispredict) ? alt_pc : '0;
            train_valid    <= resolve_en;
            train_then     <= resolve_en && actual_then;
        end
    end
endmodule

// File: rtl/branch_shadow_unit.sv
// Top of the branch shadow unit: tracks one in-flight branch, holds a
// write-inhibit shadow until it resolves, then reports success or cancel
// with a redirect to the stored alternative PC and non-speculative training.
// Assumes a single branch unit and synchronous active-low reset.
module branch_shadow_unit
    import bsu_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic            issue_pred_then,
    input  logic [PC_W-1:0] issue_alt_pc,
    output logic            issue_ready,
    input  logic            res_then,
    input  logic            res_else,
    output logic            write_inhibit,
    output logic            success,
    output logic            cancel,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic            train_valid,
    output logic            train_then,
    output logic            err
);
    bsu_state_e      state;
    logic            capture_en;
    logic            resolve_en;
    logic            pred_then;
    logic [PC_W-1:0] alt_pc;

    bsu_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_valid(issue_valid),
        .res_then   (res_then),
        .res_else   (res_else),
        .state      (state),
        .capture_en (capture_en),
        .resolve_en (resolve_en),
        .err        (err)
    );

    bsu_store #(.PC_W(PC_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_en  (capture_en),
        .pred_then_in(issue_pred_then),
        .alt_pc_in   (issue_alt_pc),
        .pred_then   (pred_then),
        .alt_pc      (alt_pc)
    );

    bsu_outcome #(.PC_W(PC_W)) u_outcome (
        .clk           (clk),
        .rst_n         (rst_n),
        .resolve_en    (resolve_en),
        .actual_then   (res_then),
        .pred_then     (pred_then),
        .alt_pc        (alt_pc),
        .success       (success),
        .cancel        (cancel),
        .redirect_valid(redirect_valid),
        .redirect_pc   (redirect_pc),
        .train_valid   (train_valid),
        .train_then    (train_then)
    );

    // Status decode from the control state.
    always_comb begin
        issue_ready   = (state == ST_IDLE);
        write_inhibit = (state == ST_SHADOW);
    end
endmodule

// File: rtl/branch_shadow_unit_checker.sv
// Port-level protocol checks for branch_shadow_unit, attached by bind.
module branch_shadow_unit_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_valid,
    input logic            issue_ready,
    input logic            res_then,
    input logic            res_else,
    input logic            write_inhibit,
    input logic            success,
    input logic            cancel,
    input logic            redirect_valid,
    input logic [PC_W-1:0] redirect_pc,
    input logic            train_valid,
    input logic            err
);
    p_inhibit_after_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ready && issue_valid) |=> write_inhibit);

    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        write_inhibit |-> !issue_ready);

    p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({success, cancel}) <= 1);

    p_outcome_drops_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (success || cancel) |-> (!write_inhibit && $past(write_inhibit)));

    p_redirect_with_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid == cancel);

    p_redirect_pc_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |-> (redirect_pc == '0));

    p_train_nonspec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        train_valid |-> (!write_inhibit && (success || cancel)));

    p_both_flags_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_then && res_else) |=> err);

    p_stray_flag_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ready && (res_then || res_else)) |=> err);

    p_pulse_then_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (success || cancel) |=> (issue_ready && !success && !cancel && !train_valid));
endmodule

bind branch_shadow_unit branch_shadow_unit_checker #(.PC_W(PC_W)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_valid   (issue_valid),
    .issue_ready   (issue_ready),
    .res_then      (res_then),
    .res_else      (res_else),
    .write_inhibit (write_inhibit),
    .success       (success),
    .cancel        (cancel),
    .redirect_valid(redirect_valid),
    .redirect_pc   (redirect_pc),
    .train_valid   (train_valid),
    .err           (err)
);

// File: tb/branch_shadow_unit_tb_top.sv
// Self-checking bench: directed corner cases followed by seeded random branches.
module branch_shadow_unit_tb_top;
    localparam int PC_W = 32;
    localparam int MAX_CYC = 200000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_valid = 1'b0;
    logic            issue_pred_then = 1'b0;
    logic [PC_W-1:0] issue_alt_pc = '0;
    logic            issue_ready;
    logic            res_then = 1'b0;
    logic            res_else = 1'b0;
    logic            write_inhibit;
    logic            success;
    logic            cancel;
    logic            redirect_valid;
    logic [PC_W-1:0] redirect_pc;
    logic            train_valid;
    logic            train_then;
    logic            err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;
    int unsigned seed = 32'd20240611;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    branch_shadow_unit #(.PC_W(PC_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .issue_valid    (issue_valid),
        .issue_pred_then(issue_pred_then),
        .issue_alt_pc   (issue_alt_pc),
        .issue_ready    (issue_ready),
        .res_then       (res_then),
        .res_else       (res_else),
        .write_inhibit  (write_inhibit),
        .success        (success),
        .cancel         (cancel),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .train_valid    (train_valid),
        .train_then     (train_then),
        .err            (err)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Advance one clock edge and settle 1 ns past it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Expected outcome from the requirements.
    function automatic bit exp_success(input bit pred, input bit actual);
        return pred == actual;
    endfunction

    task automatic check_quiet(input string req);
        check(req, "success", success, 1'b0);
        check(req, "cancel", cancel, 1'b0);
        check(req, "redirect_valid", redirect_valid, 1'b0);
        check(req, "redirect_pc", redirect_pc, '0);
        check(req, "train_valid", train_valid, 1'b0);
        check(req, "train_then", train_then, 1'b0);
    endtask

    // Full branch: issue, wait, optional error injection, resolve, check outcome.
    task automatic run_branch(input bit pred, input logic [PC_W-1:0] alt,
                              input bit actual, input int wait_cyc,
                              input bit inject_both, input bit junk_issue);
        check("R8", "issue_ready before issue", issue_ready, 1'b1);
        issue_valid = 1'b1; issue_pred_then = pred; issue_alt_pc = alt;
        step();
        issue_valid = 1'b0;
        check("R1", "write_inhibit after issue", write_inhibit, 1'b1);
        check("R2", "issue_ready while busy", issue_ready, 1'b0);
        for (int i = 0; i < wait_cyc; i++) begin
            if (junk_issue) begin
                // R2: issue while busy must not overwrite the captured values
                issue_valid = 1'b1; issue_pred_then = ~pred; issue_alt_pc = ~alt;
            end
            step();
            issue_valid = 1'b0;
            check("R3", "shadow held with no flag", write_inhibit, 1'b1);
            check("R3", "no outcome while waiting", success | cancel, 1'b0);
        end
        if (inject_both) begin
            res_then = 1'b1; res_else = 1'b1;
            step();
            res_then = 1'b0; res_else = 1'b0;
            check("R7", "err after both flags", err, 1'b1);
            check("R7", "shadow kept after both flags", write_inhibit, 1'b1);
            check("R7", "no outcome after both flags", success | cancel, 1'b0);
        end
        res_then = actual; res_else = ~actual;
        if (junk_issue) begin
            issue_valid = 1'b1; issue_pred_then = ~pred; issue_alt_pc = ~alt;
        end
        step();
        res_then = 1'b0; res_else = 1'b0;
        check("R4", "success", success, exp_success(pred, actual));
        check("R4", "cancel", cancel, !exp_success(pred, actual));
        check("R1", "write_inhibit in outcome cycle", write_inhibit, 1'b0);
        check("R5", "redirect_valid", redirect_valid, !exp_success(pred, actual));
        check("R5", "redirect_pc", redirect_pc, exp_success(pred, actual) ? '0 : alt);
        check("R6", "train_valid", train_valid, 1'b1);
        check("R6", "train_then", train_then, actual);
        check("R7", "no err on clean resolve", err, 1'b0);
        step();
        issue_valid = 1'b0;
        check_quiet("R8");
        check("R8", "issue_ready after pulse", issue_ready, 1'b1);
        check("R2", "issue in outcome cycle ignored", write_inhibit, 1'b0);
    endtask

    initial begin : watchdog
        repeat (MAX_CYC) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(seed));
        // R9: outputs during and after reset
        step(); step();
        check("R9", "write_inhibit in reset", write_inhibit, 1'b0);
        check("R9", "issue_ready in reset", issue_ready, 1'b1);
        check_quiet("R9");
        rst_n = 1'b1;
        step();
        check("R9", "write_inhibit after reset", write_inhibit, 1'b0);
        check("R9", "err after reset", err, 1'b0);

        // R7: stray flag with no shadow
        res_then = 1'b1;
        step();
        res_then = 1'b0;
        check("R7", "err for stray flag", err, 1'b1);
        check("R7", "stray flag ignored", write_inhibit, 1'b0);
        check_quiet("R7");
        step();
        check("R7", "err is one pulse", err, 1'b0);

        // Directed: all four prediction/outcome pairs
        run_branch(1'b1, 32'h0000_1000, 1'b1, 0, 1'b0, 1'b0);
        run_branch(1'b0, 32'hDEAD_BEE0, 1'b0, 2, 1'b0, 1'b0);
        run_branch(1'b1, 32'hCAFE_0040, 1'b0, 1, 1'b0, 1'b0);
        run_branch(1'b0, 32'hFFFF_FFFC, 1'b1, 3, 1'b1, 1'b1);

        // R9: reset in mid-shadow clears state and captured address
        issue_valid = 1'b1; issue_pred_then = 1'b1; issue_alt_pc = 32'h1234_5678;
        step();
        issue_valid = 1'b0;
        check("R1", "shadow before reset", write_inhibit, 1'b1);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        check("R9", "shadow cleared by reset", write_inhibit, 1'b0);
        check("R9", "ready after reset", issue_ready, 1'b1);
        res_else = 1'b1;
        step();
        res_else = 1'b0;
        check("R9", "no outcome after reset", cancel | redirect_valid, 1'b0);
        check("R7", "flag after reset is stray", err, 1'b1);
        step();

        // Random branches
        for (int n = 0; n < 400; n++) begin
            run_branch(1'($urandom), $urandom, 1'($urandom), int'($urandom % 5),
                       ($urandom % 4) == 0, ($urandom % 3) == 0);
            if (($urandom % 4) == 0) step();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule